// File: doc/BRIEF.md
# Inbound Message Dispatcher for a Mid-Level Cache Controller

This block sits in front of the protocol engine of a middle-level cache. Three inbound queues present their head messages to it. The first queue carries responses from the outer level. The second carries requests that the outer level forwards. The third carries requests and acknowledgements from the inner cache. Each cycle the dispatcher picks one eligible head and classifies it as a controller event code with a target address. The code and address are registered and presented one cycle later. The pop strobe for the chosen queue is driven combinationally in the selection cycle.

Classification depends on three things supplied from outside: the state code of the line, whether the line is present, and whether the set has a free way. When an inner access misses and the set is full, the dispatcher turns the event into a victim action on the supplied victim address. It does not dequeue the request, so the same request is classified again once room has been made. A forwarded request for a line that the inner cache still holds becomes an inner-invalidate event rather than a normal forwarded event.

Line state codes used by the block: 1 shared, 3 exclusive-clean, 5 modified, 13/14/15 those three with an inner invalidate outstanding, 17 upgrade pending with an inner invalidate outstanding (these seven form the "inner-held" set), 7 read pending, 10 read pending and already invalidated. All other codes count as not inner-held.

Top module: `msg_dispatch`

## Requirements
- R1: Among eligible heads, the response queue wins over the forwarded queue, and the forwarded queue wins over the inner queue. At most one of rspPop, fwdPop and reqPop is high in any cycle.
- R2: A head whose stall input is high is not eligible. Its queue is not popped, and the next eligible queue in priority order is served instead. With no eligible head, no pop and no event occur.
- R3: evtValid rises in the cycle after a head is selected. evtAddr equals the selected head's address, or the victim address in the R11 case. Without a selection, evtValid is low in the next cycle. After reset evtValid is low.
- R4: A response of kind 1 (exclusive data) gives event 12. A response of kind 3 (writeback ack) gives event 17.
- R5: A response of kind 0 (data) gives event 13 when rspFromPeer is high and the line state is 7 or 10. Otherwise it gives event 14 when rspPendAcks equals rspAckCnt, and event 11 in all other cases.
- R6: A response of kind 2 (ack) gives event 16 when rspPendAcks equals rspAckCnt, and event 15 otherwise.
- R7: A forwarded request of kind 0–3 for a present line whose state is in the inner-held set gives event 7 (invalidate inner for another agent).
- R8: Otherwise a forwarded request maps as follows: kind 0 (invalidate) to event 5, kinds 1 and 2 (exclusive read, upgrade) to event 9, and kind 3 (shared read) to event 10. Kinds 4–7 give event 18 (error) and are popped.
- R9: An inner message of kind 4 (invalidate with data) gives event 3. Kind 5 (invalidate ack) gives event 4. Neither depends on presence or free ways.
- R10: An inner request for a present line, or for an absent line when wayFree is high, maps as follows: kind 0 (read) to event 0, kinds 1 and 2 (write, upgrade) to event 1, and kind 3 (writeback) to event 2. Kinds 6 and 7 give event 18 and are popped.
- R11: An inner request of kind 0–3 for an absent line with wayFree low is not popped. It gives event 6 (invalidate inner for own room) on victimAddr when victimPresent is high and victimState is inner-held, and event 8 (evict) on victimAddr otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rspValid | input | 1 | Response head present |
| rspKind | input | 2 | Response kind (0 data, 1 exclusive data, 2 ack, 3 writeback ack) |
| rspAddr | input | ADDR_W | Response line address |
| rspStall | input | 1 | Response head address is stalled |
| rspFromPeer | input | 1 | Data was sent by a peer cache |
| rspAckCnt | input | ACK_W | Ack count carried by the response |
| rspPendAcks | input | ACK_W | Acks still pending for this line |
| rspLineState | input | 5 | State code of the response line |
| fwdValid | input | 1 | Forwarded head present |
| fwdKind | input | 3 | Forwarded kind (0 inv, 1 excl read, 2 upgrade, 3 shared read) |
| fwdAddr | input | ADDR_W | Forwarded line address |
| fwdStall | input | 1 | Forwarded head address is stalled |
| fwdLinePresent | input | 1 | Forwarded line is present |
| fwdLineState | input | 5 | State code of the forwarded line |
| reqValid | input | 1 | Inner head present |
| reqKind | input | 3 | Inner kind (0 read, 1 write, 2 upgrade, 3 writeback, 4 inv data, 5 inv ack) |
| reqAddr | input | ADDR_W | Inner line address |
| reqStall | input | 1 | Inner head address is stalled |
| reqLinePresent | input | 1 | Inner line is present |
| wayFree | input | 1 | The set of the inner line has a free way |
| victimAddr | input | ADDR_W | Address of the line chosen as victim |
| victimPresent | input | 1 | Victim line is present |
| victimState | input | 5 | State code of the victim line |
| rspPop | output | 1 | Dequeue the response head |
| fwdPop | output | 1 | Dequeue the forwarded head |
| reqPop | output | 1 | Dequeue the inner head |
| evtValid | output | 1 | Event valid (registered) |
| evtCode | output | 5 | Event code |
| evtAddr | output | ADDR_W | Event target address |

## Verification
Arbitration and stall skipping meet in the same cycle. The bench presents heads on two or three queues at once, with and without stall on the higher-priority ones. It judges each case by which pop strobe rises and by the event and address that follow one cycle later. A second collision occurs when the inner queue is chosen but redirected to a victim: the event must appear while reqPop stays low. The bench then re-presents the same request with a free way and expects a normal pop.

// File: rtl/msg_dispatch_pkg.sv
package msg_dispatch_pkg;
  localparam int STATE_W = 5;
  localparam int EVT_W   = 5;

  localparam logic [EVT_W-1:0] EV_LOAD       = 5'd0;
  localparam logic [EVT_W-1:0] EV_STORE      = 5'd1;
  localparam logic [EVT_W-1:0] EV_WRITEBACK  = 5'd2;
  localparam logic [EVT_W-1:0] EV_IN_DATAACK = 5'd3;
  localparam logic [EVT_W-1:0] EV_IN_ACK     = 5'd4;
  localparam logic [EVT_W-1:0] EV_INVAL      = 5'd5;
  localparam logic [EVT_W-1:0] EV_IN_INV_OWN = 5'd6;
  localparam logic [EVT_W-1:0] EV_IN_INV_OTH = 5'd7;
  localparam logic [EVT_W-1:0] EV_EVICT      = 5'd8;
  localparam logic [EVT_W-1:0] EV_FWD_EXCL   = 5'd9;
  localparam logic [EVT_W-1:0] EV_FWD_SHARED = 5'd10;
  localparam logic [EVT_W-1:0] EV_DATA       = 5'd11;
  localparam logic [EVT_W-1:0] EV_DATA_EXCL  = 5'd12;
  localparam logic [EVT_W-1:0] EV_DATA_PEER  = 5'd13;
  localparam logic [EVT_W-1:0] EV_DATA_DONE  = 5'd14;
  localparam logic [EVT_W-1:0] EV_ACK        = 5'd15;
  localparam logic [EVT_W-1:0] EV_ACK_DONE   = 5'd16;
  localparam logic [EVT_W-1:0] EV_WB_ACK     = 5'd17;
  localparam logic [EVT_W-1:0] EV_ERROR      = 5'd18;

  localparam logic [STATE_W-1:0] LS_READ_PEND     = 5'd7;
  localparam logic [STATE_W-1:0] LS_READ_PEND_INV = 5'd10;

  typedef struct packed {
    logic takeRsp;
    logic takeFwd;
    logic takeReq;
    logic redirect;
  } dispatch_strobe_t;

  function automatic logic innerHeld(input logic [STATE_W-1:0] st);
    case (st)
      5'd1, 5'd3, 5'd5, 5'd13, 5'd14, 5'd15, 5'd17: innerHeld = 1'b1;
      default: innerHeld = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/msg_dispatch_ctrl.sv
module msg_dispatch_ctrl
  import msg_dispatch_pkg::*;
(
  input  logic       rspValid,
  input  logic       rspStall,
  input  logic       fwdValid,
  input  logic       fwdStall,
  input  logic       reqValid,
  input  logic       reqStall,
  input  logic [2:0] reqKind,
  input  logic       reqLinePresent,
  input  logic       wayFree,
  output dispatch_strobe_t strobe
);
  logic rspElig, fwdElig, reqElig, reqIsAccess;

  always_comb begin
    rspElig     = rspValid & ~rspStall;
    fwdElig     = fwdValid & ~fwdStall;
    reqElig     = reqValid & ~reqStall;
    reqIsAccess = (reqKind <= 3'd3);
    strobe.takeRsp  = rspElig;
    strobe.takeFwd  = fwdElig & ~rspElig;
    strobe.takeReq  = reqElig & ~rspElig & ~fwdElig;
    strobe.redirect = strobe.takeReq & reqIsAccess & ~reqLinePresent & ~wayFree;
  end
endmodule

// File: rtl/msg_dispatch_path.sv
module msg_dispatch_path
  import msg_dispatch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ACK_W  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  dispatch_strobe_t    strobe,
  input  logic [1:0]          rspKind,
  input  logic [ADDR_W-1:0]   rspAddr,
  input  logic                rspFromPeer,
  input  logic [ACK_W-1:0]    rspAckCnt,
  input  logic [ACK_W-1:0]    rspPendAcks,
  input  logic [STATE_W-1:0]  rspLineState,
  input  logic [2:0]          fwdKind,
  input  logic [ADDR_W-1:0]   fwdAddr,
  input  logic                fwdLinePresent,
  input  logic [STATE_W-1:0]  fwdLineState,
  input  logic [2:0]          reqKind,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [ADDR_W-1:0]   victimAddr,
  input  logic                victimPresent,
  input  logic [STATE_W-1:0]  victimState,
  output logic                evtValid,
  output logic [EVT_W-1:0]    evtCode,
  output logic [ADDR_W-1:0]   evtAddr
);
  logic [EVT_W-1:0]  rspCode, fwdCode, reqCode, nextCode;
  logic [ADDR_W-1:0] nextAddr;
  logic              acksSettle, readPending;

  // Response classification
  always_comb begin
    acksSettle  = (rspPendAcks == rspAckCnt);
    readPending = (rspLineState == LS_READ_PEND) || (rspLineState == LS_READ_PEND_INV);
    case (rspKind)
      2'd0: begin
        if (rspFromPeer && readPending) rspCode = EV_DATA_PEER;
        else if (acksSettle)            rspCode = EV_DATA_DONE;
        else                            rspCode = EV_DATA;
      end
      2'd1:    rspCode = EV_DATA_EXCL;
      2'd2:    rspCode = acksSettle ? EV_ACK_DONE : EV_ACK;
      default: rspCode = EV_WB_ACK;
    endcase
  end

  // Forwarded request classification
  always_comb begin
    if (fwdKind > 3'd3)                                fwdCode = EV_ERROR;
    else if (fwdLinePresent && innerHeld(fwdLineState)) fwdCode = EV_IN_INV_OTH;
    else begin
      case (fwdKind)
        3'd0:       fwdCode = EV_INVAL;
        3'd1, 3'd2: fwdCode = EV_FWD_EXCL;
        default:    fwdCode = EV_FWD_SHARED;
      endcase
    end
  end

  // Inner message classification
  always_comb begin
    if (strobe.redirect) begin
      reqCode = (victimPresent && innerHeld(victimState)) ? EV_IN_INV_OWN : EV_EVICT;
    end else begin
      case (reqKind)
        3'd0:       reqCode = EV_LOAD;
        3'd1, 3'd2: reqCode = EV_STORE;
        3'd3:       reqCode = EV_WRITEBACK;
        3'd4:       reqCode = EV_IN_DATAACK;
        3'd5:       reqCode = EV_IN_ACK;
        default:    reqCode = EV_ERROR;
      endcase
    end
  end

  always_comb begin
    nextCode = reqCode;
    nextAddr = strobe.redirect ? victimAddr : reqAddr;
    if (strobe.takeRsp) begin
      nextCode = rspCode;
      nextAddr = rspAddr;
    end else if (strobe.takeFwd) begin
      nextCode = fwdCode;
      nextAddr = fwdAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtValid <= 1'b0;
      evtCode  <= '0;
      evtAddr  <= '0;
    end else begin
      evtValid <= strobe.takeRsp | strobe.takeFwd | strobe.takeReq;
      evtCode  <= nextCode;
      evtAddr  <= nextAddr;
    end
  end
endmodule

// File: rtl/msg_dispatch.sv
module msg_dispatch
  import msg_dispatch_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ACK_W  = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rspValid,
  input  logic [1:0]          rspKind,
  input  logic [ADDR_W-1:0]   rspAddr,
  input  logic                rspStall,
  input  logic                rspFromPeer,
  input  logic [ACK_W-1:0]    rspAckCnt,
  input  logic [ACK_W-1:0]    rspPendAcks,
  input  logic [4:0]          rspLineState,
  input  logic                fwdValid,
  input  logic [2:0]          fwdKind,
  input  logic [ADDR_W-1:0]   fwdAddr,
  input  logic                fwdStall,
  input  logic                fwdLinePresent,
  input  logic [4:0]          fwdLineState,
  input  logic                reqValid,
  input  logic [2:0]          reqKind,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic                reqStall,
  input  logic                reqLinePresent,
  input  logic                wayFree,
  input  logic [ADDR_W-1:0]   victimAddr,
  input  logic                victimPresent,
  input  logic [4:0]          victimState,
  output logic                rspPop,
  output logic                fwdPop,
  output logic                reqPop,
  output logic                evtValid,
  output logic [4:0]          evtCode,
  output logic [ADDR_W-1:0]   evtAddr
);
  dispatch_strobe_t strobe;

  msg_dispatch_ctrl uCtrl (
    .rspValid(rspValid), .rspStall(rspStall),
    .fwdValid(fwdValid), .fwdStall(fwdStall),
    .reqValid(reqValid), .reqStall(reqStall),
    .reqKind(reqKind), .reqLinePresent(reqLinePresent),
    .wayFree(wayFree), .strobe(strobe)
  );

  msg_dispatch_path #(.ADDR_W(ADDR_W), .ACK_W(ACK_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .rspKind(rspKind), .rspAddr(rspAddr), .rspFromPeer(rspFromPeer),
    .rspAckCnt(rspAckCnt), .rspPendAcks(rspPendAcks), .rspLineState(rspLineState),
    .fwdKind(fwdKind), .fwdAddr(fwdAddr), .fwdLinePresent(fwdLinePresent),
    .fwdLineState(fwdLineState),
    .reqKind(reqKind), .reqAddr(reqAddr),
    .victimAddr(victimAddr), .victimPresent(victimPresent), .victimState(victimState),
    .evtValid(evtValid), .evtCode(evtCode), .evtAddr(evtAddr)
  );

  assign rspPop = strobe.takeRsp;
  assign fwdPop = strobe.takeFwd;
  assign reqPop = strobe.takeReq & ~strobe.redirect;
endmodule

// File: rtl/msg_dispatch_checker.sv
module msg_dispatch_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              rspValid,
  input logic              rspStall,
  input logic              fwdValid,
  input logic [2:0]        fwdKind,
  input logic [ADDR_W-1:0] fwdAddr,
  input logic              fwdStall,
  input logic              fwdLinePresent,
  input logic [4:0]        fwdLineState,
  input logic              reqValid,
  input logic [2:0]        reqKind,
  input logic              reqStall,
  input logic              reqLinePresent,
  input logic              wayFree,
  input logic [ADDR_W-1:0] victimAddr,
  input logic              rspPop,
  input logic              fwdPop,
  input logic              reqPop,
  input logic              evtValid,
  input logic [4:0]        evtCode,
  input logic [ADDR_W-1:0] evtAddr
);
  logic rspElig, fwdElig, reqElig, fullMiss;
  assign rspElig  = rspValid && !rspStall;
  assign fwdElig  = fwdValid && !fwdStall;
  assign reqElig  = reqValid && !reqStall;
  assign fullMiss = reqElig && !rspElig && !fwdElig && !reqLinePresent && !wayFree && (reqKind <= 3'd3);

  assert_single_pop_R1: assert property (@(posedge clk) disable iff (!rstN)
    $countones({rspPop, fwdPop, reqPop}) <= 1);

  assert_rsp_priority_R1: assert property (@(posedge clk) disable iff (!rstN)
    rspElig |-> (rspPop && !fwdPop && !reqPop));

  assert_stall_skip_R2: assert property (@(posedge clk) disable iff (!rstN)
    (rspStall || fwdStall || reqStall) |->
      !((rspStall && rspPop) || (fwdStall && fwdPop) || (reqStall && reqPop)));

  assert_evt_follows_R3: assert property (@(posedge clk) disable iff (!rstN)
    (rspPop || fwdPop || reqPop) |=> evtValid);

  assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!rspElig && !fwdElig && !reqElig) |=> !evtValid);

  assert_fwd_addr_R3: assert property (@(posedge clk) disable iff (!rstN)
    fwdPop |=> (evtAddr == $past(fwdAddr)));

  assert_fwd_held_R7: assert property (@(posedge clk) disable iff (!rstN)
    (fwdPop && fwdLinePresent && fwdKind <= 3'd3 && fwdLineState == 5'd1) |=> (evtCode == 5'd7));

  assert_full_no_pop_R11: assert property (@(posedge clk) disable iff (!rstN)
    fullMiss |-> !reqPop);

  assert_full_victim_R11: assert property (@(posedge clk) disable iff (!rstN)
    fullMiss |=> (evtValid && evtAddr == $past(victimAddr)));
endmodule

bind msg_dispatch msg_dispatch_checker #(.ADDR_W(ADDR_W)) uChk (
  .clk(clk), .rstN(rstN), .rspValid(rspValid), .rspStall(rspStall),
  .fwdValid(fwdValid), .fwdKind(fwdKind), .fwdAddr(fwdAddr), .fwdStall(fwdStall),
  .fwdLinePresent(fwdLinePresent), .fwdLineState(fwdLineState),
  .reqValid(reqValid), .reqKind(reqKind), .reqStall(reqStall),
  .reqLinePresent(reqLinePresent), .wayFree(wayFree), .victimAddr(victimAddr),
  .rspPop(rspPop), .fwdPop(fwdPop), .reqPop(reqPop),
  .evtValid(evtValid), .evtCode(evtCode), .evtAddr(evtAddr)
);

// File: tb/msg_dispatch_test.sv
module msg_dispatch_test;
  localparam int AW = 32;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rspValid, rspStall, rspFromPeer;
  logic [1:0] rspKind;
  logic [AW-1:0] rspAddr;
  logic [CW-1:0] rspAckCnt, rspPendAcks;
  logic [4:0] rspLineState;
  logic fwdValid, fwdStall, fwdLinePresent;
  logic [2:0] fwdKind;
  logic [AW-1:0] fwdAddr;
  logic [4:0] fwdLineState;
  logic reqValid, reqStall, reqLinePresent, wayFree, victimPresent;
  logic [2:0] reqKind;
  logic [AW-1:0] reqAddr, victimAddr;
  logic [4:0] victimState;
  logic rspPop, fwdPop, reqPop, evtValid;
  logic [4:0] evtCode;
  logic [AW-1:0] evtAddr;

  int testCount = 0;
  int failCount = 0;

  typedef struct {
    logic        v;
    logic [4:0]  code;
    logic [AW-1:0] addr;
    string       tag;
  } exp_t;
  exp_t expQ[$];

  always #10 clk = ~clk;

  msg_dispatch #(.ADDR_W(AW), .ACK_W(CW)) uut (.*);

  task automatic clearAll();
    rspValid = 0; rspStall = 0; rspFromPeer = 0; rspKind = 0; rspAddr = 0;
    rspAckCnt = 0; rspPendAcks = 0; rspLineState = 0;
    fwdValid = 0; fwdStall = 0; fwdLinePresent = 0; fwdKind = 0; fwdAddr = 0; fwdLineState = 0;
    reqValid = 0; reqStall = 0; reqLinePresent = 0; wayFree = 0; victimPresent = 0;
    reqKind = 0; reqAddr = 0; victimAddr = 0; victimState = 0;
  endtask

  // Driver: inputs already set after a falling edge; check pops, queue expectation.
  task automatic step(input logic [2:0] expPops, input logic expV, input logic [4:0] expCode,
                      input logic [AW-1:0] expAddr, input string tag);
    exp_t e;
    #2;
    testCount++;
    if ({rspPop, fwdPop, reqPop} !== expPops) begin
      failCount++;
      $display("FAIL %s pops: actual %b expected %b", tag, {rspPop, fwdPop, reqPop}, expPops);
    end
    e.v = expV; e.code = expCode; e.addr = expAddr; e.tag = tag;
    expQ.push_back(e);
  endtask

  // Monitor: compare the registered event one cycle after each driven step.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        testCount++;
        if (evtValid !== e.v || (e.v && (evtCode !== e.code || evtAddr !== e.addr))) begin
          failCount++;
          $display("FAIL %s event: actual v=%b code=%0d addr=%h expected v=%b code=%0d addr=%h",
                   e.tag, evtValid, evtCode, evtAddr, e.v, e.code, e.addr);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    clearAll();
    rspValid = 1; fwdValid = 1; reqValid = 1; // heads present during reset
    repeat (3) @(posedge clk);
    #5;
    testCount++;
    if (evtValid !== 1'b0) begin
      failCount++;
      $display("FAIL R3 reset: actual evtValid=%b expected 0", evtValid);
    end
    @(negedge clk); clearAll(); rstN = 1;

    // R4
    @(negedge clk); clearAll(); rspValid = 1; rspKind = 1; rspAddr = 32'h100;
    step(3'b100, 1, 12, 32'h100, "R4 excl data");
    @(negedge clk); clearAll(); rspValid = 1; rspKind = 3; rspAddr = 32'h104;
    step(3'b100, 1, 17, 32'h104, "R4 wb ack");
    // R5
    @(negedge clk); clearAll(); rspValid = 1; rspKind = 0; rspAddr = 32'h108;
    rspLineState = 7; rspFromPeer = 1; rspPendAcks = 2; rspAckCnt = 0;
    step(3'b100, 1, 13, 32'h108, "R5 peer data");
    @(negedge clk); clearAll(); rspValid = 1; rspKind = 0; rspAddr = 32'h10C;
    rspLineState = 10; rspPendAcks = 3; rspAckCnt = 3;
    step(3'b100, 1, 14, 32'h10C, "R5 data settled");
    @(negedge clk); clearAll(); rspValid = 1; rspKind = 0; rspAddr = 32'h110;
    rspLineState = 8; rspFromPeer = 1; rspPendAcks = 3; rspAckCnt = 1;
    step(3'b100, 1, 11, 32'h110, "R5 data partial");
    // R6
    @(negedge clk); clearAll(); rspValid = 1; rspKind = 2; rspAddr = 32'h114;
    rspPendAcks = 2; rspAckCnt = 2;
    step(3'b100, 1, 16, 32'h114, "R6 ack settled");
    @(negedge clk); clearAll(); rspValid = 1; rspKind = 2; rspAddr = 32'h118;
    rspPendAcks = 2; rspAckCnt = 1;
    step(3'b100, 1, 15, 32'h118, "R6 ack partial");
    // R7
    @(negedge clk); clearAll(); fwdValid = 1; fwdKind = 3; fwdAddr = 32'h200;
    fwdLinePresent = 1; fwdLineState = 13;
    step(3'b010, 1, 7, 32'h200, "R7 held shared read");
    @(negedge clk); clearAll(); fwdValid = 1; fwdKind = 1; fwdAddr = 32'h204;
    fwdLinePresent = 1; fwdLineState = 1;
    step(3'b010, 1, 7, 32'h204, "R7 held excl read");
    // R8
    @(negedge clk); clearAll(); fwdValid = 1; fwdKind = 0; fwdAddr = 32'h208;
    fwdLinePresent = 1; fwdLineState = 2;
    step(3'b010, 1, 5, 32'h208, "R8 inval");
    @(negedge clk); clearAll(); fwdValid = 1; fwdKind = 2; fwdAddr = 32'h20C;
    fwdLineState = 5;
    step(3'b010, 1, 9, 32'h20C, "R8 upgrade absent");
    @(negedge clk); clearAll(); fwdValid = 1; fwdKind = 3; fwdAddr = 32'h210;
    fwdLinePresent = 1; fwdLineState = 6;
    step(3'b010, 1, 10, 32'h210, "R8 shared read");
    @(negedge clk); clearAll(); fwdValid = 1; fwdKind = 5; fwdAddr = 32'h214;
    fwdLinePresent = 1; fwdLineState = 1;
    step(3'b010, 1, 18, 32'h214, "R8 bad kind");
    // R9
    @(negedge clk); clearAll(); reqValid = 1; reqKind = 4; reqAddr = 32'h300;
    step(3'b001, 1, 3, 32'h300, "R9 inv data");
    @(negedge clk); clearAll(); reqValid = 1; reqKind = 5; reqAddr = 32'h304;
    step(3'b001, 1, 4, 32'h304, "R9 inv ack");
    // R10
    @(negedge clk); clearAll(); reqValid = 1; reqKind = 0; reqAddr = 32'h308; reqLinePresent = 1;
    step(3'b001, 1, 0, 32'h308, "R10 read hit");
    @(negedge clk); clearAll(); reqValid = 1; reqKind = 2; reqAddr = 32'h30C; wayFree = 1;
    step(3'b001, 1, 1, 32'h30C, "R10 upgrade free way");
    @(negedge clk); clearAll(); reqValid = 1; reqKind = 3; reqAddr = 32'h310; reqLinePresent = 1;
    step(3'b001, 1, 2, 32'h310, "R10 writeback");
    @(negedge clk); clearAll(); reqValid = 1; reqKind = 7; reqAddr = 32'h314;
    step(3'b001, 1, 18, 32'h314, "R10 bad kind");
    // R11
    @(negedge clk); clearAll(); reqValid = 1; reqKind = 1; reqAddr = 32'h400;
    victimAddr = 32'h900; victimPresent = 1; victimState = 15;
    step(3'b000, 1, 6, 32'h900, "R11 victim inner held");
    @(negedge clk); clearAll(); reqValid = 1; reqKind = 0; reqAddr = 32'h404;
    victimAddr = 32'h904; victimPresent = 1; victimState = 4;
    step(3'b000, 1, 8, 32'h904, "R11 victim evict");
    @(negedge clk); clearAll(); reqValid = 1; reqKind = 0; reqAddr = 32'h404;
    victimAddr = 32'h908; victimPresent = 0; victimState = 1;
    step(3'b000, 1, 8, 32'h908, "R11 victim absent");
    @(negedge clk); clearAll(); reqValid = 1; reqKind = 0; reqAddr = 32'h404; wayFree = 1;
    step(3'b001, 1, 0, 32'h404, "R11 retry after room");
    // R1
    @(negedge clk); clearAll(); rspValid = 1; rspKind = 3; rspAddr = 32'h500;
    fwdValid = 1; fwdKind = 0; fwdAddr = 32'h504; reqValid = 1; reqKind = 4; reqAddr = 32'h508;
    step(3'b100, 1, 17, 32'h500, "R1 three heads");
    @(negedge clk); rspValid = 0;
    step(3'b010, 1, 5, 32'h504, "R1 fwd over req");
    @(negedge clk); fwdValid = 0;
    step(3'b001, 1, 3, 32'h508, "R1 req last");
    // R2
    @(negedge clk); clearAll(); rspValid = 1; rspStall = 1; rspKind = 1; rspAddr = 32'h600;
    fwdValid = 1; fwdKind = 3; fwdAddr = 32'h604; reqValid = 1; reqKind = 5; reqAddr = 32'h608;
    step(3'b010, 1, 10, 32'h604, "R2 rsp stalled");
    @(negedge clk); fwdStall = 1;
    step(3'b001, 1, 4, 32'h608, "R2 rsp fwd stalled");
    @(negedge clk); reqStall = 1;
    step(3'b000, 0, 0, 0, "R2 all stalled");
    // R3 idle
    @(negedge clk); clearAll();
    step(3'b000, 0, 0, 0, "R3 idle");

    @(negedge clk); clearAll();
    repeat (3) @(negedge clk);
    testCount++;
    if (expQ.size() != 0) begin
      failCount++;
      $display("FAIL R3 drain: actual %0d pending expected 0", expQ.size());
    end
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule